// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Window

This block lets a host bus read up to four serial NOR flash devices as if they were one linear memory. The top two bits of the 64 MiB window address pick the device, and the low 24 bits are the byte offset inside it. For each accepted read the block pulls that device's select low. It then sends the standard single-bit read command (opcode 0x03 followed by a 24-bit address) in SPI mode 0 and shifts in a burst of data bytes. When the last bit has arrived it returns the whole burst in one response.

Two configuration inputs bound the window, both counted in 512 KiB units: the total size of the window and the size of each device. A read outside either bound, or any write, gets an error response at once and never touches the flash. A stall input keeps new host accesses from starting while software runs its own transfers on the same pins. There is no clock divider: the serial clock runs at half the bus clock.

The host holds its request until it sees the one-cycle response pulse.

Top module: `flash_xip_window`

## Requirements
- R1: The device is picked by address bits [25:24]. During an access only `cs_n[sel]` is low, and all selects are high when idle.
- R2: Each access sends opcode 0x03 and then address bits [23:0], most significant bit first, on `mosi`. `sck` idles low, and `mosi` changes only while `sck` is low (mode 0).
- R3: `burst_cfg` values 0, 1, 2 and 3 read 1, 2, 4 and 16 bytes. Byte k of the burst (flash address offset+k, wrapping within 24 bits) appears in `resp_data[8k+7:8k]`, and its first received bit is its bit 7. Unused bytes are zero.
- R4: While a select is low, `sck` is high for one bus clock and low for the next. It is never high with all selects high.
- R5: A read with address greater than or equal to `cfg_total_units` × 512 KiB gets `resp_ready` with `resp_err`=1 and zero data, and no select is asserted.
- R6: A read with offset greater than or equal to `cfg_dev_units` × 512 KiB gets an error response, and no select is asserted.
- R7: A write request (`req_write`=1) gets an error response, and no select is asserted.
- R8: While `host_stall` is high no new access starts. A request that is pending starts once `host_stall` is low.
- R9: `resp_ready` stays low until the last data bit has been shifted in. It then pulses for one cycle, with all selects high, exactly 2×(32+8×bytes)+1 cycles after a request that is accepted at once.
- R10: After reset all selects are high, `sck` is low and `resp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the serial clock is derived from it |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request, held until `resp_ready` |
| req_write | input | 1 | Request is a write (always rejected) |
| req_addr | input | 26 | Byte address within the window |
| burst_cfg | input | 2 | Burst length code |
| cfg_total_units | input | 8 | Window size in 512 KiB units |
| cfg_dev_units | input | 8 | Per-device size in 512 KiB units |
| host_stall | input | 1 | Hold off new host accesses |
| resp_ready | output | 1 | One-cycle response pulse |
| resp_err | output | 1 | Response is an error |
| resp_data | output | 128 | Burst data, byte 0 in the low bits |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| cs_n | output | 4 | Active-low device selects |

## Verification
A wrong decode shows up on the first access, as the wrong select going low or a bad address in the command frame, both visible before any data returns. A bit counter or phase error moves the response pulse off its exact cycle, or shifts data bits across byte lanes, within a single burst. A broken range, write or stall gate shows up as a select falling when none should, within a cycle or two of the request.

// File: rtl/flash_win_pkg.sv
// Shared constants and helpers for the flash read window.
// Assumes single-bit SPI and a fixed 24-bit in-device address.
package flash_win_pkg;
    localparam int unsigned CMD_BITS   = 32;
    localparam logic [7:0]  OP_READ    = 8'h03;
    localparam int unsigned UNIT_SHIFT = 19;   // 512 KiB units

    // Burst code to byte count.
    function automatic logic [4:0] burst_bytes(input logic [1:0] code);
        case (code)
            2'd0:    burst_bytes = 5'd1;
            2'd1:    burst_bytes = 5'd2;
            2'd2:    burst_bytes = 5'd4;
            default: burst_bytes = 5'd16;
        endcase
    endfunction
endpackage

// File: rtl/flash_addr_decode.sv
// Splits a window address into device select and offset, and checks it
// against the configured total and per-device sizes. Purely combinational.
module flash_addr_decode #(
    parameter int unsigned ADDR_W = 26,
    parameter int unsigned OFF_W  = 24,
    parameter int unsigned CFG_W  = 8,
    localparam int unsigned SEL_W = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  total_units,
    input  logic [CFG_W-1:0]  dev_units,
    output logic [SEL_W-1:0]  sel,
    output logic [OFF_W-1:0]  offset,
    output logic              in_range
);
    import flash_win_pkg::*;
    localparam int unsigned LIM_W = CFG_W + UNIT_SHIFT;
    localparam int unsigned CMP_W = (LIM_W > ADDR_W) ? LIM_W + 1 : ADDR_W + 1;

    logic [CMP_W-1:0] total_lim, dev_lim, addr_x, off_x;

    // Size limits and the range check.
    always_comb begin
        sel       = addr[ADDR_W-1:OFF_W];
        offset    = addr[OFF_W-1:0];
        total_lim = CMP_W'({total_units, {UNIT_SHIFT{1'b0}}});
        dev_lim   = CMP_W'({dev_units, {UNIT_SHIFT{1'b0}}});
        addr_x    = CMP_W'(addr);
        off_x     = CMP_W'(offset);
        in_range  = (addr_x < total_lim) && (off_x < dev_lim);
    end
endmodule

// File: rtl/flash_read_seq.sv
// Runs one single-bit SPI read: opcode, 24-bit address, then N data bytes.
// Serial clock is clk/2, mode 0. Assumes start is only pulsed when idle.
module flash_read_seq #(
    parameter int unsigned NUM_DEV   = 4,
    parameter int unsigned OFF_W     = 24,
    parameter int unsigned MAX_BYTES = 16,
    localparam int unsigned SEL_W  = $clog2(NUM_DEV),
    localparam int unsigned DATA_W = MAX_BYTES * 8,
    localparam int unsigned IDX_W  = $clog2(DATA_W),
    localparam int unsigned BIT_W  = $clog2(32 + DATA_W + 1),
    localparam int unsigned NB_W   = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SEL_W-1:0]  sel,
    input  logic [OFF_W-1:0]  offset,
    input  logic [NB_W-1:0]   nbytes,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_DEV-1:0] cs_n
);
    import flash_win_pkg::*;
    typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_DONE} seq_state_t;

    seq_state_t          state;
    logic [CMD_BITS-1:0] shreg;
    logic [BIT_W-1:0]    bitcnt, last_bit;
    logic                phase;
    logic [NUM_DEV-1:0]  sel_hot;
    logic [IDX_W-1:0]    rx_idx;

    // One-hot select decode, one compare per device.
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_sel
        assign sel_hot[g] = (sel == SEL_W'(g));
    end

    // Bit position of the incoming data bit: byte-major, MSB first.
    always_comb begin
        rx_idx = IDX_W'(bitcnt - BIT_W'(CMD_BITS)) ^ IDX_W'(7);
        busy   = (state != S_IDLE);
    end

    // Sequencer: frame control, shifting and sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            last_bit <= '0;
            phase    <= 1'b0;
            sck      <= 1'b0;
            mosi     <= 1'b0;
            cs_n     <= '1;
            done     <= 1'b0;
            rdata    <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    done <= 1'b0;
                    if (start) begin
                        state    <= S_SHIFT;
                        cs_n     <= ~sel_hot;
                        shreg    <= {OP_READ, offset};
                        mosi     <= OP_READ[7];
                        bitcnt   <= '0;
                        phase    <= 1'b0;
                        last_bit <= BIT_W'(CMD_BITS - 1) + BIT_W'({nbytes, 3'b000});
                        rdata    <= '0;
                    end
                end
                S_SHIFT: begin
                    if (!phase) begin
                        sck   <= 1'b1;
                        phase <= 1'b1;
                    end else begin
                        sck   <= 1'b0;
                        phase <= 1'b0;
                        if (bitcnt >= BIT_W'(CMD_BITS))
                            rdata[rx_idx] <= miso;
                        if (bitcnt == last_bit) begin
                            state <= S_DONE;
                            cs_n  <= '1;
                            done  <= 1'b1;
                            mosi  <= 1'b0;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                            shreg  <= shreg << 1;
                            mosi   <= shreg[CMD_BITS-2];
                        end
                    end
                end
                default: begin
                    done  <= 1'b0;
                    state <= S_IDLE;
                end
            endcase
        end
    end

    // R1: at most one device selected at a time.
    a_r1_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R2: mosi holds still while sck is high.
    a_r2_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi));
    // R4: sck high lasts one cycle.
    a_r4_sck_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
        sck |=> !sck);
    // R4: no clock without a select.
    a_r4_sck_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !(&cs_n));
    // R9: completion is a single pulse with selects released.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&cs_n));
endmodule

// File: rtl/flash_xip_window.sv
// Top of the memory-mapped flash read window. Accepts one host read at a
// time, rejects writes and out-of-range reads with an error pulse, and
// gates new accesses with host_stall. Assumes the host holds its request
// stable until resp_ready.
module flash_xip_window #(
    parameter int unsigned ADDR_W    = 26,
    parameter int unsigned OFF_W     = 24,
    parameter int unsigned CFG_W     = 8,
    parameter int unsigned MAX_BYTES = 16,
    localparam int unsigned SEL_W   = ADDR_W - OFF_W,
    localparam int unsigned NUM_DEV = 1 << SEL_W,
    localparam int unsigned DATA_W  = MAX_BYTES * 8,
    localparam int unsigned NB_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         burst_cfg,
    input  logic [CFG_W-1:0]   cfg_total_units,
    input  logic [CFG_W-1:0]   cfg_dev_units,
    input  logic               host_stall,
    output logic               resp_ready,
    output logic               resp_err,
    output logic [DATA_W-1:0]  resp_data,
    output logic               sck,
    output logic               mosi,
    input  logic               miso,
    output logic [NUM_DEV-1:0] cs_n
);
    import flash_win_pkg::*;

    logic [SEL_W-1:0]  dec_sel;
    logic [OFF_W-1:0]  dec_off;
    logic              dec_ok, seq_busy, seq_done, accept, bad, err_q;
    logic [DATA_W-1:0] seq_data;
    logic [NB_W-1:0]   nbytes;

    flash_addr_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CFG_W(CFG_W)) u_dec (
        .addr(req_addr), .total_units(cfg_total_units), .dev_units(cfg_dev_units),
        .sel(dec_sel), .offset(dec_off), .in_range(dec_ok)
    );

    flash_read_seq #(.NUM_DEV(NUM_DEV), .OFF_W(OFF_W), .MAX_BYTES(MAX_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept && !bad), .sel(dec_sel),
        .offset(dec_off), .nbytes(nbytes), .busy(seq_busy), .done(seq_done),
        .rdata(seq_data), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // Acceptance gate and classification of the request.
    always_comb begin
        accept = req_valid && !host_stall && !seq_busy && !resp_ready;
        bad    = req_write || !dec_ok;
        nbytes = NB_W'(burst_bytes(burst_cfg));
    end

    // Error responses return one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= accept && bad;
    end

    // Response mux.
    always_comb begin
        resp_ready = err_q || seq_done;
        resp_err   = err_q;
        resp_data  = err_q ? '0 : seq_data;
    end

    // R5: rejected request answers with an error next cycle.
    a_r5_error_response: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bad) |=> (resp_ready && resp_err));
    // R7: an error response never coincides with a selected device.
    a_r7_error_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> (&cs_n));
    // R8: stall while idle keeps every device deselected next cycle.
    a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stall && (&cs_n) && !seq_busy) |=> (&cs_n));
endmodule

// File: tb/sim_flash_xip_window.sv
// Scoreboard bench: a driver pushes expected responses into a queue, a
// monitor pops and compares them; a behavioral flash answers the reads.
module sim_flash_xip_window;
    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, host_stall = 1'b0;
    logic [25:0] req_addr = '0;
    logic [1:0] burst_cfg = '0;
    logic [7:0] cfg_total_units = 8'd128, cfg_dev_units = 8'd32;
    logic resp_ready, resp_err, sck, mosi;
    logic miso = 1'b0;
    logic [127:0] resp_data;
    logic [3:0] cs_n;

    always #5 clk = ~clk;

    flash_xip_window u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .burst_cfg(burst_cfg), .cfg_total_units(cfg_total_units),
        .cfg_dev_units(cfg_dev_units), .host_stall(host_stall), .resp_ready(resp_ready),
        .resp_err(resp_err), .resp_data(resp_data), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    integer n_checks = 0, n_fail = 0;
    logic   finished = 1'b0;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] flash_byte(input logic [1:0] cs, input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ {cs, 6'b101101};
    endfunction

    // Behavioral flash device shared by all four selects.
    logic [31:0] m_cmd = '0;
    logic [1:0]  m_cs = '0;
    integer      m_bits = 0, m_dcnt = 0, m_access = 0;
    wire         desel = &cs_n;

    always @(posedge sck or posedge desel) begin
        if (desel) m_bits <= 0;
        else begin
            if (m_bits == 0) begin
                m_access <= m_access + 1;
                for (int i = 0; i < 4; i++) if (!cs_n[i]) m_cs <= 2'(i);
            end
            if (m_bits < 32) m_cmd <= {m_cmd[30:0], mosi};
            m_bits <= m_bits + 1;
        end
    end

    always @(negedge sck) begin
        if (!desel && m_bits >= 32) begin
            miso   <= flash_byte(m_cs, m_cmd[23:0] + 24'(m_dcnt / 8))[7 - (m_dcnt % 8)];
            m_dcnt <= m_dcnt + 1;
        end else m_dcnt <= 0;
    end

    // Scoreboard.
    typedef struct {
        string        req;
        logic         err;
        logic [127:0] data;
        logic [1:0]   cs;
        logic [31:0]  cmd;
    } exp_t;
    exp_t sb[$];

    // Monitor: compare each response against the queue head.
    always @(negedge clk) begin
        if (rst_n && resp_ready) begin
            if (sb.size() == 0) check("R9 unexpected response", 128'd1, 128'd0);
            else begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " resp_err"}, 128'(resp_err), 128'(e.err));
                check({e.req, " resp_data"}, resp_data, e.data);
                check("R1 cs_n at response", 128'(cs_n), 128'hF);
                if (!e.err) begin
                    check("R1 selected device", 128'(m_cs), 128'(e.cs));
                    check("R2 command frame", 128'(m_cmd), 128'(e.cmd));
                end
            end
        end
    end

    function automatic int nbytes_of(input logic [1:0] c);
        return (c == 2'd3) ? 16 : (1 << c);
    endfunction

    // Driver: issue one request, queue its expectation, wait for the reply.
    task automatic host_req(input string req, input logic [25:0] a, input logic wr,
                            input logic [1:0] bc, input logic exp_err);
        exp_t e;
        int   n, lat, acc0;
        n = nbytes_of(bc);
        e.req  = req;
        e.err  = exp_err;
        e.data = '0;
        e.cs   = a[25:24];
        e.cmd  = {8'h03, a[23:0]};
        if (!exp_err)
            for (int k = 0; k < n; k++) e.data[8*k +: 8] = flash_byte(a[25:24], a[23:0] + 24'(k));
        sb.push_back(e);
        acc0 = m_access;
        @(negedge clk);
        req_addr = a; req_write = wr; burst_cfg = bc; req_valid = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!resp_ready && lat < 2000);
        req_valid = 1'b0;
        if (exp_err) begin
            check({req, " no flash access"}, 128'(m_access - acc0), 128'd0);
            check({req, " R9 error latency"}, 128'(lat), 128'd1);
        end else
            check({req, " R9 latency"}, 128'(lat), 128'(2 * (32 + 8 * n) + 1));
    endtask

    // Watchdog.
    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset cs_n", 128'(cs_n), 128'hF);
        check("R10 reset sck", 128'(sck), 128'd0);
        check("R10 reset resp_ready", 128'(resp_ready), 128'd0);

        // R3 burst lengths on several devices.
        host_req("R3 burst1 dev0", 26'h000_1234, 1'b0, 2'd0, 1'b0);
        host_req("R3 burst2 dev1", 26'h1AB_CDEF, 1'b0, 2'd1, 1'b0);
        host_req("R3 burst4 dev2", 26'h255_AA55, 1'b0, 2'd2, 1'b0);
        host_req("R3 burst16 dev3", 26'h3C0_0F00, 1'b0, 2'd3, 1'b0);
        // R3 burst wraps inside the device at the top of its region.
        host_req("R3 wrap dev1", 26'h1FF_FFF8, 1'b0, 2'd3, 1'b0);

        // R7 write rejected.
        host_req("R7 write", 26'h000_0100, 1'b1, 2'd2, 1'b1);

        // R5 total-size bound at 48 MiB.
        cfg_total_units = 8'd96;
        host_req("R5 last in range", 26'h2FF_FFFF, 1'b0, 2'd0, 1'b0);
        host_req("R5 first out of range", 26'h300_0000, 1'b0, 2'd0, 1'b1);
        cfg_total_units = 8'd128;

        // R6 per-device bound at 8 MiB.
        cfg_dev_units = 8'd16;
        host_req("R6 below device limit", 26'h17F_FFFF, 1'b0, 2'd0, 1'b0);
        host_req("R6 at device limit", 26'h180_0000, 1'b0, 2'd0, 1'b1);
        cfg_dev_units = 8'd32;

        // R8 stall holds off a pending request.
        begin
            exp_t e;
            int   acc0;
            e.req = "R8 after stall"; e.err = 1'b0; e.cs = 2'd2;
            e.cmd = {8'h03, 24'h00_4321}; e.data = '0;
            e.data[7:0] = flash_byte(2'd2, 24'h00_4321);
            sb.push_back(e);
            acc0 = m_access;
            @(negedge clk);
            host_stall = 1'b1;
            req_addr = 26'h200_4321; req_write = 1'b0; burst_cfg = 2'd0; req_valid = 1'b1;
            repeat (20) begin
                @(negedge clk);
                if (!(&cs_n) || resp_ready) check("R8 stalled access", {cs_n, resp_ready}, 128'h1E);
            end
            check("R8 no access while stalled", 128'(m_access - acc0), 128'd0);
            host_stall = 1'b0;
            for (int c = 0; c < 2000 && !resp_ready; c++) @(negedge clk);
            req_valid = 1'b0;
            check("R8 access after release", 128'(m_access - acc0), 128'd1);
        end

        repeat (4) @(negedge clk);
        check("R9 scoreboard drained", 128'(sb.size()), 128'd0);
        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule